// File: doc/BRIEF.md
# Phase-Offset Two-Pulse Gate Driver

This block drives an isolated power switch through two short pulses per period. A reference counter and a follower counter run at the same rate over the same period. Each one raises a fixed-width pulse when it reaches the same compare point. The reference pulse discharges the gate and the follower pulse charges it, so the gate stays on for the number of cycles by which the follower leads the reference. The duty cycle is therefore the follower's count at the moment the reference sits at zero, divided by the period.

A host writes a requested lead into a held register with a one-cycle strobe, and a pending flag goes up. The request waits until the reference counter wraps. At that edge the follower counter is loaded with the request and the flag drops, so an update can never move an edge in the middle of a period. After an enable, the follower stays idle until the first wrap. This means the first pulse after start-up is always a discharge pulse. With the defaults (a 48 MHz clock, a 2400-cycle period and a 48-cycle pulse), the pulses repeat at 20 kHz and each lasts 1 µs.

Top module: `dual_phase_gate_pulser`

## Requirements
- R1: While `rst` is sampled high, both pulse outputs and `upd_pending` are low on the following cycle.
- R2: The discharge pulse rises on the (PERIOD-WIDTH+1)-th rising edge at which `en` is sampled high. It then repeats every PERIOD cycles.
- R3: Every pulse on either output that is not cut short by `en` falling or by reset stays high for exactly WIDTH cycles.
- R4: Once a lead O (0 < O < PERIOD) has been applied, the charge pulse rises exactly O cycles before the next rise of the discharge pulse.
- R5: After reset or after `en` rises, no charge pulse starts before the first discharge pulse.
- R6: A `host_wr` strobe raises `upd_pending` on the next cycle. The flag stays high until the follower is loaded at a reference wrap, then drops on the next cycle. A strobe at the same edge as that load leaves the flag high.
- R7: A new lead takes effect only at the reference wrap. Any charge pulse earlier in the same period still uses the previous lead.
- R8: A requested lead equal to or greater than PERIOD is held as PERIOD-1.
- R9: While `en` is low, both outputs are low from the next cycle onward and both counters restart from zero. Re-enabling behaves as in R2 and R5. The held lead and the pending flag are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds outputs low and counters at zero |
| host_wr | input | 1 | One-cycle strobe that captures `host_offset` |
| host_offset | input | $clog2(PERIOD) | Requested lead of the follower counter, in cycles |
| upd_pending | output | 1 | High while a captured lead awaits the next reference wrap |
| pulse_chg | output | 1 | Registered charge pulse from the follower counter |
| pulse_dis | output | 1 | Registered discharge pulse from the reference counter |

## Verification
Timing of each result:
- The pending flag reacts one cycle after a strobe, or one cycle after the wrap edge that performs the load.
- Both outputs fall one cycle after `en` is sampled low.
- The first discharge rise is due PERIOD-WIDTH+1 enabled edges after start.
- A written lead shows up in the charge timing only in the period after the next wrap.

The bench updates its reference model on the rising edge and compares it with the design at the following falling edge. Its targeted checks measure rise-to-rise distances in cycles counted from those same rising edges. A strobe is placed on the very edge of a wrap load to exercise the collision case of R6.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

  // Follower counter waits idle after enable until the first reference wrap.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_LIVE = 1'b1
  } phase_state_e;

endpackage

// File: rtl/pgd_phase_counter.sv
module pgd_phase_counter
  import pgd_pkg::*;
#(
  parameter int PERIOD   = 2400,
  parameter int WIDTH    = 48,
  parameter bit FOLLOWER = 1'b0,
  localparam int CW      = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          fire,
  output logic          idle
);

  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] START = CW'(PERIOD - WIDTH);
  // The reference runs at once; the follower waits for its first load.
  localparam phase_state_e RST_ST = phase_state_e'(!FOLLOWER);

  phase_state_e st;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      st  <= RST_ST;
    end else if (load) begin
      cnt <= load_val;
      st  <= PH_LIVE;
    end else if (st == PH_LIVE) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign fire = en && (st == PH_LIVE) && (cnt == START);
  assign idle = (st == PH_IDLE);

endmodule

// File: rtl/pgd_pulse_shot.sv
module pgd_pulse_shot #(
  parameter int WIDTH = 48,
  localparam int WW   = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fire,
  output logic pulse
);

  logic [WW-1:0] left;

  // Fixed-length one-shot: a trigger during an active pulse is ignored,
  // so a pulse is never shortened or stretched by counter reloads.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pulse <= 1'b0;
      left  <= '0;
    end else if (!pulse) begin
      if (fire) begin
        pulse <= 1'b1;
        left  <= WW'(WIDTH - 1);
      end
    end else if (left == '0) begin
      pulse <= 1'b0;
    end else begin
      left <= left - 1'b1;
    end
  end

endmodule

// File: rtl/pgd_offset_port.sv
module pgd_offset_port #(
  parameter int PERIOD      = 2400,
  parameter int INIT_OFFSET = 0,
  localparam int CW         = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wr_offset,
  input  logic          take,
  output logic [CW-1:0] held_offset,
  output logic          pending
);

  logic          over;
  logic [CW-1:0] clamped;

  assign over    = {1'b0, wr_offset} >= (CW+1)'(PERIOD);
  assign clamped = over ? CW'(PERIOD - 1) : wr_offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_offset <= CW'(INIT_OFFSET);
      pending     <= 1'b0;
    end else begin
      if (wr) held_offset <= clamped;
      // A fresh request beats a load on the same edge.
      if (wr)        pending <= 1'b1;
      else if (take) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/dual_phase_gate_pulser.sv
module dual_phase_gate_pulser #(
  parameter int PERIOD      = 2400,
  parameter int WIDTH       = 48,
  parameter int INIT_OFFSET = 0,
  localparam int CW         = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          host_wr,
  input  logic [CW-1:0] host_offset,
  output logic          upd_pending,
  output logic          pulse_chg,
  output logic          pulse_dis
);

  localparam int NSHOT = 2;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0]    a_cnt, b_cnt, held_offset;
  logic             a_fire, b_fire, a_idle, b_idle;
  logic             a_wrap, ld;
  logic [NSHOT-1:0] trig, shot;

  pgd_offset_port #(.PERIOD(PERIOD), .INIT_OFFSET(INIT_OFFSET)) u_port (
    .clk(clk), .rst(rst), .wr(host_wr), .wr_offset(host_offset),
    .take(ld), .held_offset(held_offset), .pending(upd_pending)
  );

  pgd_phase_counter #(.PERIOD(PERIOD), .WIDTH(WIDTH), .FOLLOWER(1'b0)) u_ref (
    .clk(clk), .rst(rst), .en(en), .load(1'b0), .load_val('0),
    .cnt(a_cnt), .fire(a_fire), .idle(a_idle)
  );

  // Safe point: the reference is about to return to zero.
  assign a_wrap = en && !a_idle && (a_cnt == LAST);
  assign ld     = a_wrap && (upd_pending || b_idle);

  pgd_phase_counter #(.PERIOD(PERIOD), .WIDTH(WIDTH), .FOLLOWER(1'b1)) u_fol (
    .clk(clk), .rst(rst), .en(en), .load(ld), .load_val(held_offset),
    .cnt(b_cnt), .fire(b_fire), .idle(b_idle)
  );

  assign trig = {b_fire, a_fire};

  for (genvar g = 0; g < NSHOT; g++) begin : g_shot
    pgd_pulse_shot #(.WIDTH(WIDTH)) u_shot (
      .clk(clk), .rst(rst), .en(en), .fire(trig[g]), .pulse(shot[g])
    );
  end

  assign pulse_dis = shot[0];
  assign pulse_chg = shot[1];

endmodule

// File: rtl/dual_phase_gate_pulser_chk.sv
module dual_phase_gate_pulser_chk #(
  parameter int PERIOD = 2400,
  parameter int WIDTH  = 48,
  localparam int CW    = $clog2(PERIOD),
  localparam int RW    = $clog2(WIDTH + 1) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          host_wr,
  input logic [CW-1:0] host_offset,
  input logic          upd_pending,
  input logic          pulse_chg,
  input logic          pulse_dis,
  input logic [CW-1:0] a_cnt,
  input logic [CW-1:0] b_cnt,
  input logic          b_idle,
  input logic          ld,
  input logic [CW-1:0] held_offset
);

  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [RW-1:0] run_dis, run_chg;
  logic          seen_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_dis  <= '0;
      run_chg  <= '0;
      seen_dis <= 1'b0;
    end else begin
      run_dis  <= pulse_dis ? run_dis + 1'b1 : '0;
      run_chg  <= pulse_chg ? run_chg + 1'b1 : '0;
      seen_dis <= en && (seen_dis || pulse_dis);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pulse_dis && !pulse_chg && !upd_pending));

  a_r3_dis_width: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_dis) && $past(en) && !$past(rst)) |-> (run_dis == RW'(WIDTH)));

  a_r3_chg_width: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_chg) && $past(en) && !$past(rst)) |-> (run_chg == RW'(WIDTH)));

  a_r5_discharge_first: assert property (@(posedge clk) disable iff (rst)
    pulse_chg |-> seen_dis);

  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> upd_pending);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (upd_pending && !ld) |=> upd_pending);

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (ld && !host_wr) |=> !upd_pending);

  a_r7_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !b_idle && !$past(b_idle) && ($past(b_cnt) != LAST)
     && (b_cnt != $past(b_cnt) + 1'b1)) |-> ($past(a_cnt) == LAST));

  a_r8_clamp: assert property (@(posedge clk) disable iff (rst)
    (host_wr && ({1'b0, host_offset} >= (CW+1)'(PERIOD))) |=> (held_offset == LAST));

  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pulse_dis && !pulse_chg && (a_cnt == '0) && b_idle));

endmodule

bind dual_phase_gate_pulser dual_phase_gate_pulser_chk #(
  .PERIOD(PERIOD), .WIDTH(WIDTH)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .host_wr(host_wr), .host_offset(host_offset),
  .upd_pending(upd_pending), .pulse_chg(pulse_chg), .pulse_dis(pulse_dis),
  .a_cnt(a_cnt), .b_cnt(b_cnt), .b_idle(b_idle), .ld(ld),
  .held_offset(held_offset)
);

// File: tb/dual_phase_gate_pulser_bench.sv
`timescale 1ns/1ps
module dual_phase_gate_pulser_bench;

  localparam int P  = 40;
  localparam int W  = 4;
  localparam int S  = P - W;
  localparam int CW = $clog2(P);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          host_wr = 1'b0;
  logic [CW-1:0] host_offset = '0;
  logic          upd_pending, pulse_chg, pulse_dis;

  dual_phase_gate_pulser #(.PERIOD(P), .WIDTH(W), .INIT_OFFSET(0)) u_dual_phase_gate_pulser (
    .clk(clk), .rst(rst), .en(en), .host_wr(host_wr), .host_offset(host_offset),
    .upd_pending(upd_pending), .pulse_chg(pulse_chg), .pulse_dis(pulse_dis)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit started = 0, done = 0;

  // behavioural reference state
  int m_a = 0, m_b = 0, m_off = 0, m_ca = 0, m_cb = 0;
  bit m_live = 0, m_pend = 0;

  // observed edges
  int dis_rises = 0, chg_rises = 0, last_dis = 0, last_chg = 0;
  int run_dis = 0, run_chg = 0, last_w_dis = 0, last_w_chg = 0;
  bit prev_dis = 0, prev_chg = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    bit fa, fb, wr, ld;
    cyc++;
    started = 1;
    if (rst) begin
      m_a = 0; m_b = 0; m_live = 0; m_ca = 0; m_cb = 0; m_pend = 0; m_off = 0;
    end else begin
      fa = en && (m_a == S);
      fb = en && m_live && (m_b == S);
      wr = en && (m_a == P - 1);
      ld = wr && (m_pend || !m_live);
      if (!en)           m_ca = 0;
      else if (m_ca > 0) m_ca = m_ca - 1;
      else if (fa)       m_ca = W;
      if (!en)           m_cb = 0;
      else if (m_cb > 0) m_cb = m_cb - 1;
      else if (fb)       m_cb = W;
      if (!en) begin
        m_a = 0; m_b = 0; m_live = 0;
      end else begin
        m_a = (m_a + 1) % P;
        if (ld) begin
          m_b = m_off; m_live = 1;
        end else if (m_live) begin
          m_b = (m_b + 1) % P;
        end
      end
      if (host_wr)  m_pend = 1;
      else if (ld)  m_pend = 0;
      if (host_wr)  m_off = (int'(host_offset) >= P) ? P - 1 : int'(host_offset);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(pulse_dis === (m_ca > 0), "R2", "pulse_dis vs model", int'(pulse_dis), int'(m_ca > 0));
      check(pulse_chg === (m_cb > 0), "R4", "pulse_chg vs model", int'(pulse_chg), int'(m_cb > 0));
      check(upd_pending === m_pend, "R6", "upd_pending vs model", int'(upd_pending), int'(m_pend));
    end
    if (pulse_dis && !prev_dis) begin dis_rises++; last_dis = cyc; end
    if (pulse_chg && !prev_chg) begin chg_rises++; last_chg = cyc; end
    if (pulse_dis) run_dis++;
    else if (prev_dis) begin last_w_dis = run_dis; run_dis = 0; end
    if (pulse_chg) run_chg++;
    else if (prev_chg) begin last_w_chg = run_chg; run_chg = 0; end
    prev_dis = pulse_dis;
    prev_chg = pulse_chg;
  end

  task automatic write_offset(input int v);
    host_offset = CW'(v);
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int en_edge, t1, c0;
    repeat (3) @(negedge clk);
    check(!pulse_dis && !pulse_chg && !upd_pending, "R1", "outputs in reset",
          int'({pulse_dis, pulse_chg, upd_pending}), 0);
    rst = 1'b0;
    @(negedge clk);

    write_offset(10);
    check(upd_pending === 1'b1, "R6", "pending after strobe", int'(upd_pending), 1);

    en = 1'b1;
    en_edge = cyc + 1;
    wait (dis_rises >= 1);
    check(last_dis == en_edge + S, "R2", "first discharge rise edge", last_dis, en_edge + S);
    check(chg_rises == 0, "R5", "charge pulses before first discharge", chg_rises, 0);
    t1 = last_dis;

    wait (dis_rises >= 2);
    check(last_dis - t1 == P, "R2", "discharge spacing", last_dis - t1, P);
    check(last_dis - last_chg == 10, "R4", "charge lead 10", last_dis - last_chg, 10);
    check(upd_pending === 1'b0, "R6", "pending cleared after load", int'(upd_pending), 0);

    wait (dis_rises >= 3);
    check(last_w_dis == W, "R3", "discharge width", last_w_dis, W);
    check(last_w_chg == W, "R3", "charge width", last_w_chg, W);

    // R7: request a new lead early in the period; this period keeps the old one
    repeat (6) @(negedge clk);
    write_offset(20);
    wait (dis_rises >= 4);
    check(last_dis - last_chg == 10, "R7", "old lead kept before wrap", last_dis - last_chg, 10);
    wait (dis_rises >= 5);
    check(last_dis - last_chg == 20, "R7", "new lead after wrap", last_dis - last_chg, 20);

    // R8: oversized request held as P-1
    write_offset(50);
    wait (dis_rises >= 7);
    check(last_dis - last_chg == P - 1, "R8", "clamped lead", last_dis - last_chg, P - 1);
    check(last_w_chg == W, "R3", "charge width at large lead", last_w_chg, W);

    // R9: drop enable in the middle of a discharge pulse
    wait (dis_rises >= 8);
    en = 1'b0;
    @(negedge clk);
    check(!pulse_dis && !pulse_chg, "R9", "outputs low when disabled",
          int'({pulse_dis, pulse_chg}), 0);
    repeat (4) @(negedge clk);
    check(!pulse_dis && !pulse_chg, "R9", "outputs stay low", int'({pulse_dis, pulse_chg}), 0);
    write_offset(5);
    c0 = chg_rises;
    en = 1'b1;
    en_edge = cyc + 1;
    wait (dis_rises >= 9);
    check(last_dis == en_edge + S, "R9", "restart discharge edge", last_dis, en_edge + S);
    check(chg_rises == c0, "R5", "no charge before discharge after restart", chg_rises - c0, 0);

    // R6: a strobe that lands on the same edge as the wrap load
    host_offset = CW'(15);
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
    host_offset = CW'(25);
    host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    check(upd_pending === 1'b1, "R6", "pending kept on colliding strobe", int'(upd_pending), 1);
    wait (dis_rises >= 10);
    check(last_dis - last_chg == 15, "R6", "lead loaded at collision", last_dis - last_chg, 15);
    wait (dis_rises >= 11);
    check(last_dis - last_chg == 25, "R4", "lead after following wrap", last_dis - last_chg, 25);
    check(upd_pending === 1'b0, "R6", "pending cleared at last", int'(upd_pending), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule